// File: doc/BRIEF.md
# Reference Validation Timer Logic

This block decides, for each of a set of clock reference inputs (eight by default), whether that reference may be treated as valid. Each channel combines a fault indication from an external reference monitor with two static control bits, a monitor bypass and a monitor override, into one combined fault. A channel's reference becomes valid only after a programmable validation timer has counted its full period in millisecond ticks while that fault stays clear. Any fault drops the valid flag and restarts the timer from zero.

For test and bring-up, the override bit can force a fault. With bypass set, the override bit replaces the monitor entirely, so an external monitor can drive validation. A self-clearing force strobe sets the valid flag exactly as a timer expiry would. Channels share only the clock, the reset and the millisecond tick, and are otherwise fully independent.

Top module: `ref_validator`

## Requirements
- R1: The block holds NUM_REFS (default 8) independent channels. Bit i of every per-channel port belongs to channel i, and stimulus on one channel never changes another channel's `ref_valid` bit.
- R2: When `mon_bypass[i]`=1, the combined fault of channel i equals `mon_override[i]`, and `mon_fault[i]` has no effect.
- R3: When `mon_bypass[i]`=0, the combined fault is 1 if `mon_override[i]`=1 and equals `mon_fault[i]` otherwise. With all three control inputs at 0 it follows the monitor fault alone.
- R4: A combined fault sampled at a rising clock edge clears `ref_valid[i]` at that edge. The flag stays 0 for as long as the fault lasts, whatever the other inputs are.
- R5: While the combined fault is 1 the channel's timer is held at zero. Once the fault clears, the timer expires on the (L+1)-th `ms_tick` it samples, where L is `tmr_limit[i]`. `ref_valid[i]` rises at the clock edge that follows the edge sampling that tick.
- R6: A fault that returns while the timer is counting discards the partial count. After the fault clears again, the full L+1 ticks are needed.
- R7: After it expires, the timer stops until the next fault. `ref_valid[i]` then stays 1 while no fault occurs, however many further ticks arrive.
- R8: A 1 on `force_wr[i]` sampled at an edge sets an internal strobe that clears itself on the next edge. If channel i is unfaulted, the strobe sets `ref_valid[i]` at that next edge. If channel i is faulted, the strobe has no effect and leaves nothing pending once the fault clears.
- R9: A `tmr_limit[i]` of 0 makes the timer expire on the first tick sampled after the fault clears.
- R10: After a synchronous active-high `rst`, every `ref_valid` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond, shared by all channels |
| mon_fault | input | NUM_REFS | Fault indication from the reference monitor, one bit per channel |
| mon_bypass | input | NUM_REFS | 1 = ignore the monitor and take the fault from the override bit |
| mon_override | input | NUM_REFS | Forces a fault (bypass 0) or supplies the fault (bypass 1) |
| force_wr | input | NUM_REFS | Write pulse to the self-clearing force-expiry bit |
| tmr_limit | input | NUM_REFS x CNT_W | Per-channel validation period in ticks (terminal count L) |
| ref_valid | output | NUM_REFS | Per-channel valid flag |

## Verification
The timer path is tried with a staircase of limits 0 through 7, one per channel. Every channel is fed the same tick train, so each channel must turn valid on its own tick. This separates an off-by-one in the terminal count from a wrong expiry latency or crosstalk between channels. A fault pulse in the middle of a count, with fewer ticks left than the limit, shows whether the count really restarts. The mux is tried with every combination of bypass, override and monitor fault, each against a channel whose previous valid state would expose a mux that is ignored. A force strobe issued into a faulted channel and followed by a fault release with no ticks shows whether the strobe clears itself.

// File: rtl/refval_pkg.sv
package refval_pkg;

    localparam int REF_COUNT = 8;
    localparam int TMR_BITS  = 16;

    // Per-channel controls that select the combined fault
    typedef struct packed {
        logic bypass;
        logic override_bit;
        logic monitor_fault;
    } fault_ctl_t;

    typedef enum logic [0:0] {
        TS_ARMED = 1'b0,
        TS_SPENT = 1'b1
    } tmr_state_t;

    // Combined fault: the override either replaces the monitor or forces a fault
    function automatic logic combine_fault(input fault_ctl_t c);
        if (c.bypass)
            return c.override_bit;
        else
            return c.override_bit | c.monitor_fault;
    endfunction

endpackage

// File: rtl/refval_strobe.sv
module refval_strobe (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    output logic pulse
);
    // Bit is set by a write and clears itself on the following edge
    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= wr & ~pulse;
    end

    p_strobe_selfclear_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(wr));

endmodule

// File: rtl/refval_timer.sv
module refval_timer
    import refval_pkg::*;
#(
    parameter int CNT_W = TMR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             faulted,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    tmr_state_t       st;

    always_ff @(posedge clk) begin
        if (rst || faulted) begin
            cnt    <= '0;
            st     <= TS_ARMED;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (st == TS_ARMED && tick) begin
                if (cnt >= limit) begin
                    expire <= 1'b1;
                    st     <= TS_SPENT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_fault_halts_r5: assert property (@(posedge clk) disable iff (rst)
        faulted |=> (cnt == '0 && !expire));

    p_expire_once_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    p_expire_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(expire) |-> $past(tick));

endmodule

// File: rtl/refval_latch.sv
module refval_latch (
    input  logic clk,
    input  logic rst,
    input  logic faulted,
    input  logic trig,
    output logic valid
);
    // Fault acts as the latch reset; a trigger captures the inverted fault
    always_ff @(posedge clk) begin
        if (rst || faulted)
            valid <= 1'b0;
        else if (trig)
            valid <= ~faulted;
    end

    p_fault_clears_r4: assert property (@(posedge clk) disable iff (rst)
        faulted |=> !valid);

    p_trig_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (trig && !faulted) |=> valid);

    p_valid_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && !faulted) |=> valid);

endmodule

// File: rtl/refval_channel.sv
module refval_channel
    import refval_pkg::*;
#(
    parameter int CNT_W = TMR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  fault_ctl_t       ctl,
    input  logic             force_wr,
    input  logic [CNT_W-1:0] limit,
    output logic             valid
);
    logic faulted;
    logic expire;
    logic strobe;
    logic trig;

    always_comb faulted = combine_fault(ctl);
    always_comb trig    = expire | strobe;

    refval_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .wr    (force_wr),
        .pulse (strobe)
    );

    refval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .faulted (faulted),
        .limit   (limit),
        .expire  (expire)
    );

    refval_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .faulted (faulted),
        .trig    (trig),
        .valid   (valid)
    );

    p_valid_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(expire || strobe));

    p_bypass_blocks_mon_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.bypass && !ctl.override_bit && valid) |=> valid);

endmodule

// File: rtl/ref_validator.sv
module ref_validator
    import refval_pkg::*;
#(
    parameter int NUM_REFS = REF_COUNT,
    parameter int CNT_W    = TMR_BITS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ms_tick,
    input  logic [NUM_REFS-1:0]            mon_fault,
    input  logic [NUM_REFS-1:0]            mon_bypass,
    input  logic [NUM_REFS-1:0]            mon_override,
    input  logic [NUM_REFS-1:0]            force_wr,
    input  logic [NUM_REFS-1:0][CNT_W-1:0] tmr_limit,
    output logic [NUM_REFS-1:0]            ref_valid
);
    // R1: one fully independent channel per reference
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ch
        fault_ctl_t ctl;
        always_comb begin
            ctl.bypass        = mon_bypass[g];
            ctl.override_bit  = mon_override[g];
            ctl.monitor_fault = mon_fault[g];
        end

        refval_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (ms_tick),
            .ctl      (ctl),
            .force_wr (force_wr[g]),
            .limit    (tmr_limit[g]),
            .valid    (ref_valid[g])
        );
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        $past(rst) |-> (ref_valid == '0));

endmodule

// File: tb/tb_ref_validator.sv
module tb_ref_validator;
    localparam int N = 8;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic [N-1:0] mon_fault = '1;
    logic [N-1:0] mon_bypass = '0;
    logic [N-1:0] mon_override = '0;
    logic [N-1:0] force_wr = '0;
    logic [N-1:0][W-1:0] tmr_limit;
    logic [N-1:0] ref_valid;

    always #10 clk = ~clk;

    ref_validator #(.NUM_REFS(N), .CNT_W(W)) dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .mon_fault(mon_fault), .mon_bypass(mon_bypass),
        .mon_override(mon_override), .force_wr(force_wr),
        .tmr_limit(tmr_limit), .ref_valid(ref_valid)
    );

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic push_exp(input logic [N-1:0] e, input string t);
        sb_item_t it;
        it.exp = e;
        it.tag = t;
        sb_q.push_back(it);
    endtask

    // Monitor: compares queued expectations shortly after the driver's negedge
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            #1;
            it = sb_q.pop_front();
            total++;
            if (ref_valid !== it.exp) begin
                bad++;
                $display("FAIL %s: ref_valid=%h expected=%h", it.tag, ref_valid, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: ref_valid=%h expected=finish", ref_valid);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) tmr_limit[i] = 16'(i);
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        push_exp(8'h00, "R10 reset");

        // Staircase: channel i expires on tick i+1 (R5, R9, R1)
        mon_fault = '0;
        for (int k = 1; k <= N; k++) begin
            tick1();
            push_exp(8'((1 << (k - 1)) - 1), "R5 latency");
            @(negedge clk);
            push_exp(8'((1 << k) - 1), k == 1 ? "R9 zero limit" : "R1 R5 staircase");
        end

        // R7: further ticks do nothing
        for (int k = 0; k < 4; k++) begin tick1(); @(negedge clk); end
        push_exp(8'hFF, "R7 stays valid");

        // R4: fault on channel 3
        mon_fault[3] = 1'b1;
        @(negedge clk);
        push_exp(8'hF7, "R4 fault clears");
        tick1(); tick1(); @(negedge clk);
        push_exp(8'hF7, "R4 held while faulted");

        // R6: partial count discarded
        mon_fault[3] = 1'b0;
        tick1(); @(negedge clk); tick1(); @(negedge clk);
        push_exp(8'hF7, "R6 partial");
        mon_fault[3] = 1'b1;
        @(negedge clk) mon_fault[3] = 1'b0;
        for (int k = 0; k < 3; k++) begin tick1(); @(negedge clk); end
        push_exp(8'hF7, "R6 restart needs full count");
        tick1();
        push_exp(8'hF7, "R6 latency");
        @(negedge clk);
        push_exp(8'hFF, "R6 expiry");

        // R2: bypass ignores monitor
        mon_bypass[5] = 1'b1;
        mon_fault[5]  = 1'b1;
        cyc(3);
        push_exp(8'hFF, "R2 monitor ignored");
        mon_override[5] = 1'b1;
        @(negedge clk);
        push_exp(8'hDF, "R2 override faults");
        mon_override[5] = 1'b0;
        for (int k = 0; k < 5; k++) begin tick1(); @(negedge clk); end
        push_exp(8'hDF, "R2 counting");
        tick1(); @(negedge clk);
        push_exp(8'hFF, "R2 valid with monitor fault");
        mon_bypass[5] = 1'b0;
        @(negedge clk);
        push_exp(8'hDF, "R3 monitor used when not bypassed");

        // R3: override forces fault without bypass
        mon_override[6] = 1'b1;
        mon_fault[5] = 1'b0;
        @(negedge clk);
        push_exp(8'h9F, "R3 override forces fault");
        mon_override[6] = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            tick1(); @(negedge clk);
            if (k == 6) push_exp(8'hBF, "R3 ch5 back");
        end
        push_exp(8'hFF, "R3 ch6 back");

        // R8: force strobe
        mon_fault[2] = 1'b1;
        @(negedge clk) mon_fault[2] = 1'b0;
        push_exp(8'hFB, "R8 before force");
        @(negedge clk) force_wr[2] = 1'b1;
        @(negedge clk) force_wr[2] = 1'b0;
        push_exp(8'hFB, "R8 strobe registered");
        @(negedge clk);
        push_exp(8'hFF, "R8 force sets valid");

        mon_override[4] = 1'b1;
        @(negedge clk);
        push_exp(8'hEF, "R8 faulted ch4");
        force_wr[4] = 1'b1;
        @(negedge clk) force_wr[4] = 1'b0;
        cyc(3);
        push_exp(8'hEF, "R8 force ignored under fault");
        mon_override[4] = 1'b0;
        cyc(3);
        push_exp(8'hEF, "R8 strobe not pending");
        @(negedge clk) force_wr[4] = 1'b1;
        @(negedge clk) force_wr[4] = 1'b0;
        @(negedge clk);
        push_exp(8'hFF, "R8 force after clear");

        // R10: reset again
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        push_exp(8'h00, "R10 second reset");

        wait (sb_q.size() == 0);
        #5;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule